// File: doc/BRIEF.md
# Card Reset Controller

This block gathers reset requests from four places on a card and turns them into a single active-low reset that stays low for a fixed number of periods of a 4 MHz reference. The reference arrives as a one-cycle enable, `tick_4m`, in the system clock domain. The front-panel switch, the network fabric and the cache controller drive asynchronous level requests, and each passes through a two-flop synchroniser. The fourth source is an internal missed-tick watchdog. It counts regular timer ticks and fires when a set number of them pass with no kick from software.

While a request is present the pulse counter stays at zero. The reset therefore ends a fixed number of reference periods after the last cycle in which any request was seen. A request that comes in while the reset is already active restarts that count.

When a reset begins from idle, the block records every source that is asserting in one-hot form. That record survives the reset it describes, so software can read why the card restarted. The local `rst_n` is the controller's own power-on reset. It clears the record and starts one full pulse.

Top module: `card_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `card_rst_n` is 0 and `reset_cause` is 4'b0000. After `rst_n` rises, `card_rst_n` stays 0 for exactly PULSE_TICKS (default 256) reference ticks and then goes to 1.
- R2: A request on `panel_req`, `fabric_req` or `cache_req` that is set up before clock edge P1 drives `card_rst_n` low after edge P3. After edge P2 it is still high.
- R3: `card_rst_n` rises after exactly PULSE_TICKS clock edges that sample `tick_4m` high, counted after the last edge at which a synchronised request was seen. This holds for a request held as a level over many cycles.
- R4: A request that arrives while `card_rst_n` is low restarts the full PULSE_TICKS count and leaves `reset_cause` unchanged.
- R5: When a reset begins from idle, `reset_cause` takes the one-hot code bit0 = panel, bit1 = fabric, bit2 = watchdog, bit3 = cache. Every source asserting in that cycle sets its bit.
- R6: `reset_cause` keeps its value after `card_rst_n` returns to 1, and until the next reset begins.
- R7: When WD_LIMIT (8 bits, default 16) `wd_tick` pulses arrive with no kick, `card_rst_n` falls at the edge after the one that samples the last tick, and the cause is 4'b0100. WD_LIMIT−1 ticks cause no reset.
- R8: `wd_kick` clears the missed-tick count. A kick and a tick in the same cycle leave the count at zero.
- R9: The watchdog count is held at zero while `card_rst_n` is low, so ticks seen during a reset do not count toward the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the controller |
| tick_4m | input | 1 | One-cycle enable at the 4 MHz reference rate |
| panel_req | input | 1 | Asynchronous front-panel reset request (level) |
| fabric_req | input | 1 | Asynchronous network-fabric reset request (level) |
| cache_req | input | 1 | Asynchronous cache-controller reset request (level) |
| wd_tick | input | 1 | Synchronous one-cycle regular timer tick |
| wd_kick | input | 1 | Synchronous one-cycle watchdog service pulse |
| card_rst_n | output | 1 | Active-low card reset |
| reset_cause | output | 4 | One-hot record of the sources that began the last reset |

## Verification
A fault in the pulse counter shows at the ports as a reset that rises too early or too late. That error appears only at the end of the pulse, so every pulse is measured in reference ticks counted from the last request the block could have seen. A watchdog count that is not cleared, or is cleared at the wrong time, shows up only WD_LIMIT ticks later, as an unexpected reset with cause 4'b0100. For that reason the watchdog cases stop one tick short of the limit and then check that the reset stays high. A cause register that is updated at the wrong moment is caught by a restart during an active reset, and by reading the register again long after the release.

// File: rtl/rstc_pkg.sv
// Package: shared constants and types for the card reset controller.
// Assumes four reset sources. The bit order of the cause code is fixed here
// because software decodes it.
package rstc_pkg;
    localparam int unsigned NUM_SRC    = 4;
    localparam int unsigned SRC_PANEL  = 0;
    localparam int unsigned SRC_FABRIC = 1;
    localparam int unsigned SRC_WDOG   = 2;
    localparam int unsigned SRC_CACHE  = 3;
    typedef logic [NUM_SRC-1:0] cause_t;
endpackage

// File: rtl/rstc_sync.sv
// Module: rstc_sync
// Multi-bit, multi-stage synchroniser for asynchronous level requests.
// Each bit is synchronised on its own. It assumes the inputs are levels that
// last longer than one clock, so no multi-bit coherence is needed.
// The flops clear on the synchronous active-low reset.
module rstc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift each request through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/rstc_watchdog.sv
// Module: rstc_watchdog
// Missed-tick watchdog. It counts wd_tick pulses that arrive with no kick and
// holds `fire` high once the count reaches WD_LIMIT. It assumes tick and kick
// are synchronous one-cycle pulses and that WD_LIMIT is at least 1.
// hold_clr (the card reset being active) keeps the count at zero.
module rstc_watchdog #(
    parameter logic [7:0] WD_LIMIT = 8'd16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    input  logic hold_clr,
    output logic fire
);
    logic [7:0] miss_q;

    // Count missed ticks, saturating at the limit. Kick and hold_clr take priority.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr || kick) begin
            miss_q <= '0;
        end else if (tick && (miss_q != WD_LIMIT)) begin
            miss_q <= miss_q + 8'd1;
        end
    end

    assign fire = (miss_q == WD_LIMIT);

    // The count never passes the configured limit.
    assert_miss_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q <= WD_LIMIT);

    // A kick always leaves the count empty.
    assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (miss_q == 8'd0));

    // No count builds up while the card is held in reset.
    assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (miss_q == 8'd0));
endmodule

// File: rtl/rstc_pulse.sv
// Module: rstc_pulse
// Reset pulse stretcher and cause latch. Any request holds the count at zero.
// Once no request is present, the count advances on each reference tick, and
// the pulse ends after PULSE_TICKS ticks. The cause latch loads only on the
// change from idle to active. It assumes PULSE_TICKS is at least 2.
module rstc_pulse #(
    parameter int unsigned PULSE_TICKS = 256,
    parameter int unsigned NSRC        = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NSRC-1:0] req,
    output logic            active,
    output logic [NSRC-1:0] cause
);
    localparam int unsigned CW = (PULSE_TICKS > 2) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          any_req;

    assign any_req = |req;

    // Start, restart or time out the pulse. Load the cause on a new start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt_q  <= '0;
            cause  <= '0;
        end else if (any_req) begin
            if (!active) cause <= req;
            active <= 1'b1;
            cnt_q  <= '0;
        end else if (active && tick) begin
            if (cnt_q == LAST) begin
                active <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // The counter stays inside the pulse window.
    assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // A request during an active pulse keeps it active and restarts the count.
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && any_req) |=> (active && cnt_q == '0));

    // The cause changes only when a new pulse begins.
    assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(active)) |-> $stable(cause));

    // At each new start the cause equals the requests seen at that edge.
    assert_cause_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(active)) |-> (cause == $past(req)));
endmodule

// File: rtl/card_reset_ctrl.sv
// Module: card_reset_ctrl (top)
// Merges the panel, fabric, cache and watchdog reset sources into a single
// stretched active-low card reset, and keeps a one-hot record of the cause.
// The three external requests are asynchronous levels. The watchdog inputs and
// tick_4m are synchronous to clk.
module card_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 256,
    parameter logic [7:0]  WD_LIMIT    = 8'd16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_4m,
    input  logic         panel_req,
    input  logic         fabric_req,
    input  logic         cache_req,
    input  logic         wd_tick,
    input  logic         wd_kick,
    output logic         card_rst_n,
    output logic [3:0]   reset_cause
);
    logic [2:0] ext_sync;
    logic       wd_fire;
    logic       pulse_active;
    cause_t     req_vec;
    cause_t     cause_q;

    rstc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cache_req, fabric_req, panel_req}),
        .sync_out (ext_sync)
    );

    rstc_watchdog #(.WD_LIMIT(WD_LIMIT)) i_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (wd_tick),
        .kick     (wd_kick),
        .hold_clr (pulse_active),
        .fire     (wd_fire)
    );

    // Place each source at its fixed bit of the cause code.
    always_comb begin
        req_vec             = '0;
        req_vec[SRC_PANEL]  = ext_sync[0];
        req_vec[SRC_FABRIC] = ext_sync[1];
        req_vec[SRC_WDOG]   = wd_fire;
        req_vec[SRC_CACHE]  = ext_sync[2];
    end

    rstc_pulse #(.PULSE_TICKS(PULSE_TICKS), .NSRC(NUM_SRC)) i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_4m),
        .req    (req_vec),
        .active (pulse_active),
        .cause  (cause_q)
    );

    assign card_rst_n  = ~pulse_active;
    assign reset_cause = cause_q;

    // A watchdog firing while idle puts the card into reset at the next edge.
    assert_wd_starts_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |=> !card_rst_n);
endmodule

// File: tb/test_card_reset_ctrl.sv
module test_card_reset_ctrl;
    localparam int PT = 256;
    localparam int WL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_4m = 1'b0;
    logic panel_req = 1'b0, fabric_req = 1'b0, cache_req = 1'b0;
    logic wd_tick = 1'b0, wd_kick = 1'b0;
    logic card_rst_n;
    logic [3:0] reset_cause;

    int n_chk = 0;
    int n_fail = 0;
    int dens = 100;
    int unsigned tick_tot = 0;
    int unsigned cyc = 0;

    card_reset_ctrl #(.PULSE_TICKS(PT), .WD_LIMIT(8'(WL))) i_card_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_4m(tick_4m),
        .panel_req(panel_req), .fabric_req(fabric_req), .cache_req(cache_req),
        .wd_tick(wd_tick), .wd_kick(wd_kick),
        .card_rst_n(card_rst_n), .reset_cause(reset_cause)
    );

    always #5 clk = ~clk;

    // Reference tick pattern, changed away from the active edge.
    always @(negedge clk) tick_4m <= (int'($urandom_range(99)) < dens);

    // Count reference ticks that the design samples while in reset.
    always @(posedge clk) if (rst_n && !card_rst_n && tick_4m) tick_tot <= tick_tot + 1;

    // Watchdog against a hung run.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [3:0] exp_cause(input logic p, input logic f,
                                             input logic w, input logic c);
        return {c, w, f, p};
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wait_release();
        int k = 0;
        while (card_rst_n !== 1'b1 && k < 20000) begin
            @(negedge clk);
            k++;
        end
        check(card_rst_n === 1'b1, "R3 release timeout", k, 20000);
    endtask

    // Drive a mask of external requests {cache,fabric,panel} for `hold` cycles,
    // then stop at the negedge after the last edge that can see them.
    task automatic drive_req(input logic [2:0] m, input int hold);
        {cache_req, fabric_req, panel_req} = m;
        repeat (hold) @(negedge clk);
        {cache_req, fabric_req, panel_req} = 3'b000;
        repeat (2) @(negedge clk);
    endtask

    task automatic wd_pulse(input logic with_kick);
        wd_tick = 1'b1; wd_kick = with_kick;
        @(negedge clk);
        wd_tick = 1'b0; wd_kick = 1'b0;
        @(negedge clk);
    endtask

    task automatic kick();
        wd_kick = 1'b1;
        @(negedge clk);
        wd_kick = 1'b0;
    endtask

    initial begin
        int unsigned snap;
        void'($urandom(32'd20240611));

        // R1: power-on state and pulse
        repeat (5) @(negedge clk);
        check(card_rst_n == 1'b0, "R1 reset low", int'(card_rst_n), 0);
        check(reset_cause == 4'b0000, "R1 cause clear", int'(reset_cause), 0);
        dens = 60;
        snap = tick_tot;
        rst_n = 1'b1;
        wait_release();
        check(tick_tot - snap == PT, "R1 pulse ticks", int'(tick_tot - snap), PT);
        check(reset_cause == 4'b0000, "R1 cause after", int'(reset_cause), 0);
        repeat (10) @(negedge clk);

        // R2/R5/R3/R6: single-cycle panel request
        panel_req = 1'b1;
        @(negedge clk);
        panel_req = 1'b0;
        @(negedge clk);
        check(card_rst_n == 1'b1, "R2 still high after P2", int'(card_rst_n), 1);
        @(negedge clk);
        check(card_rst_n == 1'b0, "R2 low after P3", int'(card_rst_n), 0);
        check(reset_cause == exp_cause(1,0,0,0), "R5 panel bit", int'(reset_cause), 1);
        snap = tick_tot;
        wait_release();
        check(tick_tot - snap == PT, "R3 pulse ticks", int'(tick_tot - snap), PT);
        repeat (50) @(negedge clk);
        check(reset_cause == exp_cause(1,0,0,0), "R6 cause kept", int'(reset_cause), 1);

        // R3: level request held over many cycles, sparse ticks
        dens = 35;
        drive_req(3'b010, 40);
        check(reset_cause == exp_cause(0,1,0,0), "R5 fabric bit", int'(reset_cause), 2);
        snap = tick_tot;
        wait_release();
        check(tick_tot - snap == PT, "R3 level ticks", int'(tick_tot - snap), PT);
        repeat (8) @(negedge clk);

        // R4: restart while active, cause unchanged
        dens = 100;
        drive_req(3'b100, 1);
        check(reset_cause == exp_cause(0,0,0,1), "R5 cache bit", int'(reset_cause), 8);
        repeat (60) @(negedge clk);
        drive_req(3'b001, 2);
        check(card_rst_n == 1'b0, "R4 still active", int'(card_rst_n), 0);
        check(reset_cause == exp_cause(0,0,0,1), "R4 cause unchanged", int'(reset_cause), 8);
        snap = tick_tot;
        wait_release();
        check(tick_tot - snap == PT, "R4 restarted ticks", int'(tick_tot - snap), PT);

        // R5: simultaneous sources
        repeat (5) @(negedge clk);
        drive_req(3'b101, 1);
        check(reset_cause == exp_cause(1,0,0,1), "R5 multi", int'(reset_cause), 9);
        wait_release();
        repeat (5) @(negedge clk);

        // R7/R8: watchdog
        kick();
        repeat (WL - 1) wd_pulse(1'b0);
        repeat (5) @(negedge clk);
        check(card_rst_n == 1'b1, "R7 no fire at limit-1", int'(card_rst_n), 1);
        wd_pulse(1'b1);
        repeat (WL - 1) wd_pulse(1'b0);
        repeat (5) @(negedge clk);
        check(card_rst_n == 1'b1, "R8 kick with tick clears", int'(card_rst_n), 1);
        wd_tick = 1'b1;
        @(negedge clk);
        wd_tick = 1'b0;
        @(negedge clk);
        check(card_rst_n == 1'b0, "R7 fire", int'(card_rst_n), 0);
        check(reset_cause == exp_cause(0,0,1,0), "R7 cause", int'(reset_cause), 4);
        wait_release();

        // R8: plain kick clears the count
        repeat (WL - 2) wd_pulse(1'b0);
        kick();
        repeat (WL - 1) wd_pulse(1'b0);
        repeat (5) @(negedge clk);
        check(card_rst_n == 1'b1, "R8 kick clears", int'(card_rst_n), 1);

        // R9: count held clear during reset
        drive_req(3'b001, 1);
        repeat (WL + 10) wd_pulse(1'b0);
        wait_release();
        repeat (WL - 1) wd_pulse(1'b0);
        repeat (5) @(negedge clk);
        check(card_rst_n == 1'b1, "R9 no carry-over", int'(card_rst_n), 1);
        check(reset_cause == exp_cause(1,0,0,0), "R9 cause panel", int'(reset_cause), 1);
        kick();

        // Random mix of sources, hold lengths and tick densities (R3, R5)
        for (int it = 0; it < 12; it++) begin
            logic [2:0] m;
            int hold;
            m = 3'($urandom_range(7));
            if (m == 3'b000) m = 3'b011;
            hold = int'($urandom_range(1, 6));
            dens = int'($urandom_range(30, 100));
            repeat (int'($urandom_range(3, 20))) @(negedge clk);
            drive_req(m, hold);
            check(reset_cause == exp_cause(m[0], m[1], 1'b0, m[2]), "R5 random cause",
                  int'(reset_cause), int'(exp_cause(m[0], m[1], 1'b0, m[2])));
            snap = tick_tot;
            wait_release();
            check(tick_tot - snap == PT, "R3 random ticks", int'(tick_tot - snap), PT);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule